// File: doc/BRIEF.md
# Quarter-Rate Polyphase Carrier Mixer

This block moves a complex baseband stream onto a real carrier placed at one quarter of the aggregate sample rate. The baseband has already been interpolated to the final serial rate and split into `LANES` parallel lanes. Each clock the block takes one block of `LANES` consecutive complex samples and returns `LANES` real samples. Lane `k` of the `m`-th accepted block stands for sample instant `m*LANES + k`, so the lanes together carry one continuous carrier.

At a quarter of the sample rate the cosine takes only the values 1, 0, -1, 0 and the sine only 0, 1, 0, -1. Each mixed output is therefore a selected and possibly negated copy of I or Q, and no multiplier is needed. A two-bit block phase register advances by `LANES mod 4` for every accepted block. Each lane adds its own fixed offset to that phase. The mixed result is formed at `IN_W+1` bits and then truncated to `OUT_W` bits by dropping least-significant bits.

Both data interfaces use valid/ready. A block is accepted on a rising edge where `s_valid` and `s_ready` are both high. `s_ready` is high whenever the output register is empty or is being read in the same cycle. While `m_valid` is high and `m_ready` is low, the output block stays unchanged and no new block is accepted.

Top module: `fs4_polyphase_duc`

## Requirements
- R1: A synchronous reset (`rst` high on a rising edge) clears `m_valid`, and the first block accepted after reset starts at sample instant 0 on lane 0.
- R2: Lane `k` of the `m`-th block accepted since reset (counting from 0) uses phase `p = (m*LANES + k) mod 4`.
- R3: The full-width result is I for p=0, -Q for p=1, -I for p=2 and Q for p=3 (that is, I·cos − Q·sin). It is computed at `IN_W+1` signed bits, and the output keeps bits `[IN_W : IN_W+1-OUT_W]`, which is an arithmetic truncation.
- R4: Negating the most negative input value does not wrap, because the full-width intermediate has one extra bit.
- R5: An accepted block appears on `m_data` with `m_valid` high on the next rising edge. With `m_ready` high and no new block accepted, `m_valid` falls after one cycle.
- R6: `s_ready` equals `!m_valid || m_ready`. While `m_valid` is high and `m_ready` is low, `m_data` and `m_valid` stay unchanged.
- R7: Cycles where no block is accepted (because `s_valid` is low or `s_ready` is low) do not use up sample instants.
- R8: Lane `k` occupies `s_i[k*IN_W +: IN_W]`, `s_q[k*IN_W +: IN_W]` and `m_data[k*OUT_W +: OUT_W]`. Inputs are two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst | input | 1 | Synchronous reset, active high |
| s_valid | input | 1 | Input block valid |
| s_ready | output | 1 | Input block ready |
| s_i | input | LANES*IN_W | In-phase samples, lane 0 in the low bits |
| s_q | input | LANES*IN_W | Quadrature samples, lane 0 in the low bits |
| m_valid | output | 1 | Output block valid |
| m_ready | input | 1 | Output block ready |
| m_data | output | LANES*OUT_W | Real mixed samples, lane 0 in the low bits |

## Verification
The assertions check on every cycle that an accepted block produces a valid output on the next edge, that an output drains when it is read and nothing new arrives, and that a stalled output holds still. They also track the phase of lane 0 independently and check its mixed value against that phase. The value of every other lane, the way rejected cycles leave the phase unchanged, the wrap-free negation of the most negative code, and the restart at instant zero after a mid-stream reset are shown only by the bench scenarios. In those scenarios a behavioural model counts sample instants across random gaps, random back-pressure and resets.

// File: rtl/fs4duc_pkg.sv
package fs4duc_pkg;
  // Quarter-rate oscillator phase: cos/sin = (1,0),(0,1),(-1,0),(0,-1)
  typedef enum logic [1:0] {
    LO_P0 = 2'd0,
    LO_P1 = 2'd1,
    LO_P2 = 2'd2,
    LO_P3 = 2'd3
  } lo_phase_t;

  function automatic lo_phase_t lo_step(lo_phase_t p, logic [1:0] inc);
    logic [1:0] s;
    s = p + inc;
    return lo_phase_t'(s);
  endfunction
endpackage

// File: rtl/duc_phase_gen.sv
module duc_phase_gen #(
  parameter int LANES = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 adv,
  output logic [2*LANES-1:0]   lane_ph
);
  import fs4duc_pkg::*;
  localparam logic [1:0] BLK_STEP = 2'(LANES % 4);

  lo_phase_t base_q;

  always_ff @(posedge clk) begin
    if (rst)      base_q <= LO_P0;
    else if (adv) base_q <= lo_step(base_q, BLK_STEP);
  end

  for (genvar k = 0; k < LANES; k++) begin : g_off
    localparam logic [1:0] OFF = 2'(k % 4);
    assign lane_ph[2*k +: 2] = lo_step(base_q, OFF);
  end
endmodule

// File: rtl/duc_lane_mixer.sv
module duc_lane_mixer #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 16
) (
  input  logic [IN_W-1:0]  i_in,
  input  logic [IN_W-1:0]  q_in,
  input  logic [1:0]       ph,
  output logic [OUT_W-1:0] y
);
  import fs4duc_pkg::*;
  localparam int FW = IN_W + 1;

  logic signed [FW-1:0] ext_i, ext_q, full;

  assign ext_i = {i_in[IN_W-1], i_in};
  assign ext_q = {q_in[IN_W-1], q_in};

  always_comb begin
    unique case (lo_phase_t'(ph))
      LO_P0:   full = ext_i;
      LO_P1:   full = -ext_q;
      LO_P2:   full = -ext_i;
      default: full = ext_q;
    endcase
  end

  assign y = full[FW-1 -: OUT_W];
endmodule

// File: rtl/duc_out_stage.sv
module duc_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst)           out_valid <= 1'b0;
    else if (in_ready) out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) out_data <= in_data;
  end
endmodule

// File: rtl/fs4_polyphase_duc.sv
module fs4_polyphase_duc #(
  parameter int LANES = 64,
  parameter int IN_W  = 16,
  parameter int OUT_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   s_valid,
  output logic                   s_ready,
  input  logic [LANES*IN_W-1:0]  s_i,
  input  logic [LANES*IN_W-1:0]  s_q,
  output logic                   m_valid,
  input  logic                   m_ready,
  output logic [LANES*OUT_W-1:0] m_data
);
  localparam int DW = LANES * OUT_W;

  logic [2*LANES-1:0] lane_ph;
  logic [DW-1:0]      mixed;
  logic               accept;

  assign accept = s_valid && s_ready;

  duc_phase_gen #(.LANES(LANES)) u_ph (
    .clk(clk), .rst(rst), .adv(accept), .lane_ph(lane_ph)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    duc_lane_mixer #(.IN_W(IN_W), .OUT_W(OUT_W)) u_mix (
      .i_in(s_i[k*IN_W +: IN_W]),
      .q_in(s_q[k*IN_W +: IN_W]),
      .ph  (lane_ph[2*k +: 2]),
      .y   (mixed[k*OUT_W +: OUT_W])
    );
  end

  duc_out_stage #(.W(DW)) u_out (
    .clk(clk), .rst(rst),
    .in_valid(s_valid), .in_ready(s_ready), .in_data(mixed),
    .out_valid(m_valid), .out_ready(m_ready), .out_data(m_data)
  );
endmodule

// File: rtl/fs4duc_checker.sv
module fs4duc_checker #(
  parameter int LANES = 64,
  parameter int IN_W  = 16,
  parameter int OUT_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   s_valid,
  input logic                   s_ready,
  input logic [LANES*IN_W-1:0]  s_i,
  input logic [LANES*IN_W-1:0]  s_q,
  input logic                   m_valid,
  input logic                   m_ready,
  input logic [LANES*OUT_W-1:0] m_data
);
  localparam int FW = IN_W + 1;
  localparam logic [1:0] STEP = 2'(LANES % 4);

  // independent tracking of lane 0
  logic [1:0]          ctr_q, ph0_q;
  logic [IN_W-1:0]     i0_q, q0_q;
  logic signed [FW-1:0] ref_full;
  logic [OUT_W-1:0]    ref0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_q <= 2'd0;
      ph0_q <= 2'd0;
      i0_q  <= '0;
      q0_q  <= '0;
    end else if (s_valid && s_ready) begin
      ph0_q <= ctr_q;
      ctr_q <= ctr_q + STEP;
      i0_q  <= s_i[IN_W-1:0];
      q0_q  <= s_q[IN_W-1:0];
    end
  end

  always_comb begin
    case (ph0_q)
      2'd0:    ref_full = FW'($signed(i0_q));
      2'd1:    ref_full = -FW'($signed(q0_q));
      2'd2:    ref_full = -FW'($signed(i0_q));
      default: ref_full = FW'($signed(q0_q));
    endcase
    ref0 = ref_full[FW-1 -: OUT_W];
  end

  a_r5_valid_after_accept: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> m_valid);

  a_r5_drain: assert property (@(posedge clk) disable iff (rst)
    (m_valid && m_ready && !s_valid) |=> !m_valid);

  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  a_r3_lane0_value: assert property (@(posedge clk) disable iff (rst)
    m_valid |-> (m_data[OUT_W-1:0] == ref0));
endmodule

bind fs4_polyphase_duc fs4duc_checker #(.LANES(LANES), .IN_W(IN_W), .OUT_W(OUT_W)) u_chk (.*);

// File: tb/sim_fs4_polyphase_duc.sv
module sim_fs4_polyphase_duc;
  localparam int LANES = 6;
  localparam int IN_W  = 12;
  localparam int OUT_W = 10;
  localparam int SH    = IN_W + 1 - OUT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [LANES*IN_W-1:0]  s_i = '0;
  logic [LANES*IN_W-1:0]  s_q = '0;
  logic m_valid;
  logic m_ready = 1'b0;
  logic [LANES*OUT_W-1:0] m_data;

  always #10 clk = ~clk;

  fs4_polyphase_duc #(.LANES(LANES), .IN_W(IN_W), .OUT_W(OUT_W)) u0 (.*);

  int checks = 0;
  int fails  = 0;
  // behavioural model
  bit mv_m = 1'b0;
  logic [LANES*OUT_W-1:0] exp_data = '0;
  longint n_ctr = 0;
  string dtag = "R3";

  task automatic chk(input string tag, input logic [LANES*OUT_W-1:0] act,
                     input logic [LANES*OUT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // mode: 0 random, 1 most negative, 2 lane-index pattern
  task automatic step(input bit r, input bit sv, input bit mr, input int mode);
    @(negedge clk);
    chk("R5", {{(LANES*OUT_W-1){1'b0}}, m_valid}, {{(LANES*OUT_W-1){1'b0}}, mv_m});
    if (mv_m) chk(dtag, m_data, exp_data);
    rst = r; s_valid = sv; m_ready = mr;
    for (int k = 0; k < LANES; k++) begin
      if (mode == 1) begin
        s_i[k*IN_W +: IN_W] = {1'b1, {(IN_W-1){1'b0}}};
        s_q[k*IN_W +: IN_W] = {1'b1, {(IN_W-1){1'b0}}};
      end else if (mode == 2) begin
        s_i[k*IN_W +: IN_W] = IN_W'((k + 1) * 64);
        s_q[k*IN_W +: IN_W] = IN_W'(-(k + 1) * 128);
      end else begin
        s_i[k*IN_W +: IN_W] = IN_W'($urandom);
        s_q[k*IN_W +: IN_W] = IN_W'($urandom);
      end
    end
    #1;
    chk("R6", {{(LANES*OUT_W-1){1'b0}}, s_ready},
        {{(LANES*OUT_W-1){1'b0}}, (!mv_m || mr)});
    if (r) begin
      mv_m = 1'b0; n_ctr = 0;
    end else begin
      bit acc;
      acc = sv && (!mv_m || mr);
      if (mv_m && mr) mv_m = 1'b0;
      if (acc) begin
        for (int k = 0; k < LANES; k++) begin
          int iv, qv, val, p;
          iv = int'($signed(s_i[k*IN_W +: IN_W]));
          qv = int'($signed(s_q[k*IN_W +: IN_W]));
          p  = int'((n_ctr + k) % 4);
          case (p)
            0: val = iv;
            1: val = -qv;
            2: val = -iv;
            default: val = qv;
          endcase
          val = val >>> SH;
          exp_data[k*OUT_W +: OUT_W] = val[OUT_W-1:0];
        end
        n_ctr += LANES;
        mv_m = 1'b1;
      end
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset clears output valid
    repeat (3) step(1, 0, 0, 0);
    // R8: lane placement with distinct per-lane values, R2 phase per lane
    dtag = "R8";
    repeat (4) step(0, 1, 1, 2);
    // R2 / R3: continuous random stream
    dtag = "R2";
    repeat (20) step(0, 1, 1, 0);
    // R7: random gaps in input valid
    dtag = "R7";
    repeat (40) step(0, $urandom_range(0, 1) == 1, 1, 0);
    // R6: random back-pressure
    dtag = "R6";
    repeat (60) step(0, $urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0, 0);
    // R4: most negative inputs at every phase
    dtag = "R4";
    repeat (6) step(0, 1, 1, 1);
    // R5: drain
    dtag = "R5";
    repeat (3) step(0, 0, 1, 0);
    // R1: mid-stream reset, restart at instant zero
    dtag = "R1";
    repeat (3) step(0, 1, 1, 0);
    step(1, 0, 1, 0);
    repeat (8) step(0, 1, 1, 2);
    repeat (20) step(0, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 0);
    repeat (3) step(0, 0, 1, 0);
    finish_run();
  end
endmodule